// File: doc/BRIEF.md
# Prioritized UART Interrupt Identifier

This block gathers every interrupt cause of a single serial channel, holds the causes that arrive as one-cycle events until their own acknowledge action, masks all of them with a per-class enable vector, and raises one interrupt request. Alongside the request it presents a six-bit identification code for the most urgent cause still pending, so that the host can read one value and know what to service first.

The causes are modelled as inputs. These are error pushes and pops on the receive FIFO, an overrun event, a receive-timeout event, a data-ready level, a transmit-space event, a modem-line change, flow-control character detections and an RTS/CTS-change event. Single-cycle strobes report host accesses to the identification, line-status, modem-status and receive-holding registers and writes to the transmit-holding register. Each strobe acknowledges only the causes it owns. On a read of the identification register, the code is held in a capture register in the same cycle, so the value returned and the cause it acknowledges always agree. The request goes to a pad together with a drive-enable output, and the pad floats the line while the output-enable control is low.

Top module: `uart_irq_prio`

## Requirements
- R1: After reset the live code `irq_id` and the captured code `irq_id_rd` are 000001 and `irq_o` is 0. Whenever no enabled cause is pending, `irq_id` is 000001.
- R2: The line-status class (code 000110) is pending while the error-entry count is nonzero or an overrun is latched. It outranks every other class.
- R3: The receive timeout (code 001100) and data-ready (code 000100) share the second level, and the timeout is reported first. The timeout latches on `rx_tmo_evt` and clears on `rhr_rd`. Data-ready follows the `rx_data_lvl` level.
- R4: The transmit class (code 000010) is third. It latches on `tx_space_evt` and clears on `thr_wr`, or on `iir_rd` when 000010 is the code returned.
- R5: The modem class (code 000000) is fourth. It latches on `msr_chg_evt` and clears on `msr_rd`.
- R6: The flow-character class (code 010000) is fifth. A cause latched by `xoff_evt` clears only on `xon_evt`. A cause latched by `spec_evt` clears only on `lsr_rd`.
- R7: The RTS/CTS-change class (code 100000) is lowest. It latches on `flow_chg_evt` and clears on `iir_rd` only when 100000 is the code returned.
- R8: The error-entry count rises on `rx_err_push` and falls on `rx_err_pop`. The line-status class stays pending until pops equal pushes. An overrun latched by `ovr_evt` clears on `lsr_rd`.
- R9: `src_en` bit 0 enables line status, bit 1 the receive classes, bit 2 transmit, bit 3 modem, bit 4 flow characters and bit 5 RTS/CTS change. A disabled class is neither reported nor raises `irq_o`. It stays latched and is reported as soon as its enable bit is set.
- R10: `irq_o` is 1 exactly when some enabled class is pending. `irq_oe` equals `out_en`.
- R11: `irq_id_rd` takes the value `irq_id` had in the cycle of `iir_rd`. That read acknowledges only the class whose code was returned.
- R12: All events take effect at the clock edge where they are sampled, and the new code is visible after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous active-high reset |
| src_en | input | 6 | Per-class enable vector |
| out_en | input | 1 | Interrupt pad drive enable control |
| rx_err_push | input | 1 | A character with an error entered the receive FIFO |
| rx_err_pop | input | 1 | A character with an error left the receive FIFO |
| ovr_evt | input | 1 | Receive overrun event |
| rx_tmo_evt | input | 1 | Receive timeout event |
| rx_data_lvl | input | 1 | Receive data ready or trigger reached (level) |
| tx_space_evt | input | 1 | Transmit holding empty or space trigger event |
| msr_chg_evt | input | 1 | Modem line change event |
| xoff_evt | input | 1 | Xoff character(s) detected |
| xon_evt | input | 1 | Xon character(s) detected |
| spec_evt | input | 1 | Special character detected |
| flow_chg_evt | input | 1 | RTS or CTS went inactive |
| iir_rd | input | 1 | Identification register read strobe |
| lsr_rd | input | 1 | Line status register read strobe |
| msr_rd | input | 1 | Modem status register read strobe |
| rhr_rd | input | 1 | Receive holding register read strobe |
| thr_wr | input | 1 | Transmit holding register write strobe |
| irq_o | output | 1 | Interrupt request |
| irq_oe | output | 1 | Pad drive enable for the request |
| irq_id | output | 6 | Live identification code |
| irq_id_rd | output | 6 | Code captured at the last identification read |

## Verification
The hardest case to reach is a read of the identification register while a class that clears on that read is pending behind a higher-priority class. The read must acknowledge only the class it returned, and the one behind it must stay pending. The bench builds this case directly by raising the transmit and RTS/CTS-change classes together and reading twice. It also steps through all 128 combinations of pending sources and all 64 enable vectors from a fresh reset. For each combination it compares the code and the request line with a priority model computed in the bench.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
   localparam int ID_W = 6;
   localparam int NUM_CLS = 7;

   typedef enum logic [ID_W-1:0] {
      ID_NONE = 6'b000001,
      ID_LINE = 6'b000110,
      ID_TMO  = 6'b001100,
      ID_DATA = 6'b000100,
      ID_THR  = 6'b000010,
      ID_MSR  = 6'b000000,
      ID_XOFF = 6'b010000,
      ID_FLOW = 6'b100000
   } irq_id_e;

   // class order inside the pending vector
   localparam int C_LINE = 0;
   localparam int C_TMO  = 1;
   localparam int C_DATA = 2;
   localparam int C_THR  = 3;
   localparam int C_MSR  = 4;
   localparam int C_XOFF = 5;
   localparam int C_FLOW = 6;
endpackage

// File: rtl/uart_irq_flag.sv
module uart_irq_flag (
   input  logic clk,
   input  logic rst,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   // a set in the same cycle as a clear wins: the new event is not lost
   always_ff @(posedge clk or posedge rst) begin
      if (rst)        q_o <= 1'b0;
      else if (set_i) q_o <= 1'b1;
      else if (clr_i) q_o <= 1'b0;
   end
endmodule

// File: rtl/uart_irq_errcnt.sv
module uart_irq_errcnt #(
   parameter int FIFO_DEPTH = 64
) (
   input  logic clk,
   input  logic rst,
   input  logic push_i,
   input  logic pop_i,
   output logic any_o
);
   localparam int CW = $clog2(FIFO_DEPTH + 1);
   localparam logic [CW-1:0] CMAX = CW'(FIFO_DEPTH);

   if (FIFO_DEPTH < 2) begin : g_bad_depth
      $error("uart_irq_errcnt: FIFO_DEPTH must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (push_i && !pop_i && cnt_q != CMAX) begin
         cnt_q <= cnt_q + 1'b1;
      end else if (pop_i && !push_i && cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign any_o = (cnt_q != '0);
endmodule

// File: rtl/uart_irq_arb.sv
module uart_irq_arb
   import uart_irq_pkg::*;
#(
   parameter bit TMO_FIRST = 1'b1
) (
   input  logic [NUM_CLS-1:0] pend_i,
   output logic [ID_W-1:0]    id_o,
   output logic               any_o
);
   logic [ID_W-1:0] lvl2_id;
   logic            lvl2_hit;

   assign lvl2_hit = pend_i[C_TMO] | pend_i[C_DATA];

   if (TMO_FIRST) begin : g_tmo_first
      assign lvl2_id = pend_i[C_TMO] ? ID_TMO : ID_DATA;
   end else begin : g_data_first
      assign lvl2_id = pend_i[C_DATA] ? ID_DATA : ID_TMO;
   end

   always_comb begin
      if (pend_i[C_LINE])      id_o = ID_LINE;
      else if (lvl2_hit)       id_o = lvl2_id;
      else if (pend_i[C_THR])  id_o = ID_THR;
      else if (pend_i[C_MSR])  id_o = ID_MSR;
      else if (pend_i[C_XOFF]) id_o = ID_XOFF;
      else if (pend_i[C_FLOW]) id_o = ID_FLOW;
      else                     id_o = ID_NONE;
   end

   assign any_o = |pend_i;
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
   import uart_irq_pkg::*;
#(
   parameter int FIFO_DEPTH = 64,
   parameter bit TMO_FIRST  = 1'b1,
   parameter int EN_W       = 6
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [EN_W-1:0] src_en,
   input  logic            out_en,
   input  logic            rx_err_push,
   input  logic            rx_err_pop,
   input  logic            ovr_evt,
   input  logic            rx_tmo_evt,
   input  logic            rx_data_lvl,
   input  logic            tx_space_evt,
   input  logic            msr_chg_evt,
   input  logic            xoff_evt,
   input  logic            xon_evt,
   input  logic            spec_evt,
   input  logic            flow_chg_evt,
   input  logic            iir_rd,
   input  logic            lsr_rd,
   input  logic            msr_rd,
   input  logic            rhr_rd,
   input  logic            thr_wr,
   output logic            irq_o,
   output logic            irq_oe,
   output logic [ID_W-1:0] irq_id,
   output logic [ID_W-1:0] irq_id_rd
);
   if (EN_W != 6) begin : g_bad_en
      $error("uart_irq_prio: EN_W must be 6");
   end

   logic err_flag, ovr_pend, tmo_pend, thr_pend, msr_pend;
   logic xoff_pend, spec_pend, flow_pend, line_pend;
   logic [NUM_CLS-1:0] pend_raw, pend_msk;
   logic ack_thr, ack_flow, any_pend;

   uart_irq_errcnt #(.FIFO_DEPTH(FIFO_DEPTH)) u_errcnt (
      .clk(clk), .rst(rst), .push_i(rx_err_push), .pop_i(rx_err_pop),
      .any_o(err_flag)
   );

   // identification read acknowledges only the code being returned
   assign ack_thr  = iir_rd && (irq_id == ID_THR);
   assign ack_flow = iir_rd && (irq_id == ID_FLOW);

   uart_irq_flag u_ovr  (.clk(clk), .rst(rst), .set_i(ovr_evt),      .clr_i(lsr_rd),          .q_o(ovr_pend));
   uart_irq_flag u_tmo  (.clk(clk), .rst(rst), .set_i(rx_tmo_evt),   .clr_i(rhr_rd),          .q_o(tmo_pend));
   uart_irq_flag u_thr  (.clk(clk), .rst(rst), .set_i(tx_space_evt), .clr_i(thr_wr | ack_thr), .q_o(thr_pend));
   uart_irq_flag u_msr  (.clk(clk), .rst(rst), .set_i(msr_chg_evt),  .clr_i(msr_rd),          .q_o(msr_pend));
   uart_irq_flag u_xoff (.clk(clk), .rst(rst), .set_i(xoff_evt),     .clr_i(xon_evt),         .q_o(xoff_pend));
   uart_irq_flag u_spec (.clk(clk), .rst(rst), .set_i(spec_evt),     .clr_i(lsr_rd),          .q_o(spec_pend));
   uart_irq_flag u_flow (.clk(clk), .rst(rst), .set_i(flow_chg_evt), .clr_i(ack_flow),        .q_o(flow_pend));

   assign line_pend = err_flag | ovr_pend;

   always_comb begin
      pend_raw         = '0;
      pend_raw[C_LINE] = line_pend;
      pend_raw[C_TMO]  = tmo_pend;
      pend_raw[C_DATA] = rx_data_lvl;
      pend_raw[C_THR]  = thr_pend;
      pend_raw[C_MSR]  = msr_pend;
      pend_raw[C_XOFF] = xoff_pend | spec_pend;
      pend_raw[C_FLOW] = flow_pend;
   end

   assign pend_msk[C_LINE] = pend_raw[C_LINE] & src_en[0];
   assign pend_msk[C_TMO]  = pend_raw[C_TMO]  & src_en[1];
   assign pend_msk[C_DATA] = pend_raw[C_DATA] & src_en[1];
   assign pend_msk[C_THR]  = pend_raw[C_THR]  & src_en[2];
   assign pend_msk[C_MSR]  = pend_raw[C_MSR]  & src_en[3];
   assign pend_msk[C_XOFF] = pend_raw[C_XOFF] & src_en[4];
   assign pend_msk[C_FLOW] = pend_raw[C_FLOW] & src_en[5];

   uart_irq_arb #(.TMO_FIRST(TMO_FIRST)) u_arb (
      .pend_i(pend_msk), .id_o(irq_id), .any_o(any_pend)
   );

   always_ff @(posedge clk or posedge rst) begin
      if (rst)         irq_id_rd <= ID_NONE;
      else if (iir_rd) irq_id_rd <= irq_id;
   end

   assign irq_o  = any_pend;
   assign irq_oe = out_en;
endmodule

// File: rtl/uart_irq_prio_chk.sv
module uart_irq_prio_chk (
   input logic       clk,
   input logic       rst,
   input logic [5:0] src_en,
   input logic       iir_rd,
   input logic [5:0] irq_id,
   input logic [5:0] irq_id_rd,
   input logic       irq_o,
   input logic       thr_wr,
   input logic       tx_space_evt,
   input logic       thr_pend,
   input logic       msr_rd,
   input logic       msr_chg_evt,
   input logic       msr_pend,
   input logic       err_flag,
   input logic       rx_err_push,
   input logic       line_pend
);
   assert_idle_code_R1: assert property (@(posedge clk) disable iff (rst)
      !irq_o |-> irq_id == 6'b000001);

   assert_line_first_R2: assert property (@(posedge clk) disable iff (rst)
      (line_pend && src_en[0]) |-> irq_id == 6'b000110);

   assert_thr_clear_R4: assert property (@(posedge clk) disable iff (rst)
      (thr_wr && !tx_space_evt) |=> !thr_pend);

   assert_msr_clear_R5: assert property (@(posedge clk) disable iff (rst)
      (msr_rd && !msr_chg_evt) |=> !msr_pend);

   assert_err_rise_R8: assert property (@(posedge clk) disable iff (rst)
      $rose(err_flag) |-> $past(rx_err_push));

   assert_capture_R11: assert property (@(posedge clk) disable iff (rst)
      iir_rd |=> irq_id_rd == $past(irq_id));
endmodule

bind uart_irq_prio uart_irq_prio_chk u_chk (
   .clk(clk), .rst(rst), .src_en(src_en), .iir_rd(iir_rd), .irq_id(irq_id),
   .irq_id_rd(irq_id_rd), .irq_o(irq_o), .thr_wr(thr_wr),
   .tx_space_evt(tx_space_evt), .thr_pend(thr_pend), .msr_rd(msr_rd),
   .msr_chg_evt(msr_chg_evt), .msr_pend(msr_pend), .err_flag(err_flag),
   .rx_err_push(rx_err_push), .line_pend(line_pend)
);

// File: tb/uart_irq_prio_test.sv
module uart_irq_prio_test;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [5:0] src_en = 6'h3F;
   logic out_en = 1'b0;
   logic rx_err_push = 0, rx_err_pop = 0, ovr_evt = 0, rx_tmo_evt = 0;
   logic rx_data_lvl = 0, tx_space_evt = 0, msr_chg_evt = 0, xoff_evt = 0;
   logic xon_evt = 0, spec_evt = 0, flow_chg_evt = 0;
   logic iir_rd = 0, lsr_rd = 0, msr_rd = 0, rhr_rd = 0, thr_wr = 0;
   logic irq_o, irq_oe;
   logic [5:0] irq_id, irq_id_rd;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   uart_irq_prio uut (
      .clk(clk), .rst(rst), .src_en(src_en), .out_en(out_en),
      .rx_err_push(rx_err_push), .rx_err_pop(rx_err_pop), .ovr_evt(ovr_evt),
      .rx_tmo_evt(rx_tmo_evt), .rx_data_lvl(rx_data_lvl),
      .tx_space_evt(tx_space_evt), .msr_chg_evt(msr_chg_evt),
      .xoff_evt(xoff_evt), .xon_evt(xon_evt), .spec_evt(spec_evt),
      .flow_chg_evt(flow_chg_evt), .iir_rd(iir_rd), .lsr_rd(lsr_rd),
      .msr_rd(msr_rd), .rhr_rd(rhr_rd), .thr_wr(thr_wr),
      .irq_o(irq_o), .irq_oe(irq_oe), .irq_id(irq_id), .irq_id_rd(irq_id_rd)
   );

   task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   // clear all strobes/events at a falling edge
   task automatic drop;
      rx_err_push = 0; rx_err_pop = 0; ovr_evt = 0; rx_tmo_evt = 0;
      tx_space_evt = 0; msr_chg_evt = 0; xoff_evt = 0; xon_evt = 0;
      spec_evt = 0; flow_chg_evt = 0; iir_rd = 0; lsr_rd = 0;
      msr_rd = 0; rhr_rd = 0; thr_wr = 0;
   endtask

   // inputs set at a falling edge are taken at the next rising edge
   task automatic step;
      @(negedge clk);
      drop();
   endtask

   task automatic do_reset;
      rst = 1; rx_data_lvl = 0;
      drop();
      @(negedge clk);
      rst = 0;
      @(negedge clk);
   endtask

   // bench model: pending mask m bits: 0 line,1 tmo,2 data,3 thr,4 msr,5 xoff,6 flow
   function automatic logic [5:0] model(input logic [6:0] m, input logic [5:0] en);
      logic [6:0] e;
      e = m & {en[5], en[4], en[3], en[2], en[1], en[1], en[0]};
      if (e[0]) return 6'b000110;
      if (e[1]) return 6'b001100;
      if (e[2]) return 6'b000100;
      if (e[3]) return 6'b000010;
      if (e[4]) return 6'b000000;
      if (e[5]) return 6'b010000;
      if (e[6]) return 6'b100000;
      return 6'b000001;
   endfunction

   task automatic load(input logic [6:0] m);
      rx_err_push = m[0]; rx_tmo_evt = m[1]; rx_data_lvl = m[2];
      tx_space_evt = m[3]; msr_chg_evt = m[4]; xoff_evt = m[5];
      flow_chg_evt = m[6];
      step();
   endtask

   initial begin
      do_reset();
      // R1 reset state
      chk("R1 reset id", irq_id, 6'b000001);
      chk("R1 reset captured id", irq_id_rd, 6'b000001);
      chk("R1 reset irq", {5'b0, irq_o}, 6'd0);

      // R2 R3 R4 R5 R6 R7 R12: all pending combinations, all enabled
      for (int m = 0; m < 128; m++) begin
         do_reset();
         src_en = 6'h3F;
         load(m[6:0]);
         chk("R2/R12 sweep code", irq_id, model(m[6:0], 6'h3F));
         chk("R10 sweep irq", {5'b0, irq_o}, {5'b0, m != 0});
      end

      // R9: every enable vector with all classes pending
      for (int en = 0; en < 64; en++) begin
         do_reset();
         src_en = en[5:0];
         load(7'h7F);
         chk("R9 enable sweep code", irq_id, model(7'h7F, en[5:0]));
         chk("R9 enable sweep irq", {5'b0, irq_o}, {5'b0, en != 0});
      end
      src_en = 6'h3F;

      // R8 error entries counted
      do_reset();
      rx_err_push = 1; step();
      rx_err_push = 1; step();
      rx_err_pop = 1; step();
      chk("R8 one error left", irq_id, 6'b000110);
      rx_err_pop = 1; step();
      chk("R8 no error left", irq_id, 6'b000001);
      ovr_evt = 1; step();
      chk("R8 overrun pending", irq_id, 6'b000110);
      lsr_rd = 1; step();
      chk("R8 overrun cleared by lsr read", irq_id, 6'b000001);

      // R3 timeout before data, timeout cleared by rhr read
      do_reset();
      rx_tmo_evt = 1; rx_data_lvl = 1; step();
      chk("R3 timeout first", irq_id, 6'b001100);
      rhr_rd = 1; step();
      chk("R3 data after timeout cleared", irq_id, 6'b000100);
      rx_data_lvl = 0; step();
      chk("R3 data level dropped", irq_id, 6'b000001);

      // R4 transmit cleared by write and by identification read
      do_reset();
      tx_space_evt = 1; step();
      thr_wr = 1; step();
      chk("R4 cleared by thr write", irq_id, 6'b000001);
      tx_space_evt = 1; step();
      iir_rd = 1; step();
      chk("R4 cleared by iir read", irq_id, 6'b000001);
      chk("R11 captured thr code", irq_id_rd, 6'b000010);

      // R11 R7 read acknowledges only the returned code
      do_reset();
      tx_space_evt = 1; flow_chg_evt = 1; step();
      iir_rd = 1; step();
      chk("R11 flow survives thr read", irq_id, 6'b100000);
      iir_rd = 1; step();
      chk("R7 flow cleared by iir read", irq_id, 6'b000001);
      chk("R7 captured flow code", irq_id_rd, 6'b100000);
      flow_chg_evt = 1; msr_chg_evt = 1; step();
      iir_rd = 1; step();
      chk("R7 flow not cleared when modem returned", irq_id, 6'b000000);

      // R5 modem cleared by msr read
      msr_rd = 1; step();
      chk("R5 modem cleared", irq_id, 6'b100000);

      // R6 flow characters
      do_reset();
      xoff_evt = 1; step();
      lsr_rd = 1; step();
      chk("R6 xoff ignores lsr read", irq_id, 6'b010000);
      xon_evt = 1; step();
      chk("R6 xoff cleared by xon", irq_id, 6'b000001);
      spec_evt = 1; step();
      xon_evt = 1; step();
      chk("R6 special ignores xon", irq_id, 6'b010000);
      lsr_rd = 1; step();
      chk("R6 special cleared by lsr read", irq_id, 6'b000001);

      // R9 masked class stays latched
      do_reset();
      src_en = 6'b111011;
      tx_space_evt = 1; step();
      chk("R9 masked thr hidden", irq_id, 6'b000001);
      src_en = 6'h3F; step();
      chk("R9 thr shown after enable", irq_id, 6'b000010);

      // R10 pad enable
      out_en = 0; step();
      chk("R10 oe low", {5'b0, irq_oe}, 6'd0);
      out_en = 1; step();
      chk("R10 oe high", {5'b0, irq_oe}, 6'd1);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule